// File: doc/BRIEF.md
# Inter-Core Mailbox and Spinlock

This block sits between a main processor and an auxiliary processor and gives them three ways to coordinate. There is a one-word mailbox in each direction, and each mailbox raises an interrupt-pending flag toward the receiving core. There is a 2-bit hardware lock that is taken through atomic commit registers. There is also a control register that holds the auxiliary core in reset, fires a software NMI, selects how that NMI restarts the core, enables the message interrupt toward the auxiliary core, and reports the auxiliary core's sleep state.

All registers sit on one simple register bus with a 3-bit word address:

| Address | Register |
|---|---|
| 0 | CTRL |
| 1 | LOCK |
| 2 | access register A |
| 3 | access register B |
| 4 | pending flag toward main |
| 5 | message toward main |
| 6 | pending flag toward aux |
| 7 | message toward aux |

A cycle with `bus_en` high and `bus_we` high is a write. A cycle with `bus_en` high and `bus_we` low is a read. Read data is registered and appears one cycle after the read, flagged by `rd_valid`.

The lock is taken in two steps. Software first writes its tag into an access register, which keeps the value. Software then reads that same access register. The read commits the stored tag into the lock only when the lock is free. The value returned by the read tells software whether it won.

The design has three state machines:

- **Mailbox** (one per direction). States are `MB_EMPTY` and `MB_PENDING`.
  - msg-write: `MB_EMPTY` → `MB_PENDING`
  - clear-write: `MB_PENDING` → `MB_EMPTY`
- **Lock**. States are `LK_FREE` and `LK_HELD`.
  - commit-read with a nonzero tag: `LK_FREE` → `LK_HELD`
  - LOCK-write: `LK_HELD` → `LK_FREE`
- **NMI**. States are `NMI_IDLE` and `NMI_FIRE`.
  - NMI-write: `NMI_IDLE` → `NMI_FIRE`
  - `NMI_FIRE` → `NMI_IDLE` on the next cycle, unless another NMI-write arrives.

Top module: `mbx_intercore`

## Requirements
- R1: After reset, `aux_reset_hold` is 1 and `irq_main`, `irq_aux`, `aux_nmi` and `rd_valid` are 0. CTRL then reads 0x00000001 (while `aux_sleep` is 0). LOCK and both pending registers read 0.
- R2: A write to the message-toward-main register (address 5) sets the main pending flag. From the next cycle, `irq_main` is 1 and address 4 reads 1. Address 5 reads back the last word written.
- R3: A write to the message-toward-aux register (address 7) sets the aux pending flag, and address 6 reads 1. `irq_aux` equals that flag ANDed with CTRL bit 3 (message interrupt enable).
- R4: A pending flag is cleared only by a write to its pending register with data bit 0 equal to 0. Writing bit 0 = 1 does not change it. Reading the message does not change it.
- R5: A read of access register A (address 2) or B (address 3) commits that register's stored 2-bit value (the value last written to its bits 1:0) into the lock when the lock is 0 and the stored value is nonzero. Such a read returns 1.
- R6: A read of an access register while the lock is nonzero, or while the stored value is 0, leaves the lock unchanged and returns 0. The access register keeps its stored value.
- R7: Any write to LOCK (address 1) clears the lock to 0, whatever the data. LOCK reads the lock value in bits 1:0.
- R8: Writing CTRL with bit 1 = 1 makes `aux_nmi` high for exactly the following cycle. CTRL bit 1 reads 0. `aux_nmi_resume` follows CTRL bit 2: 1 means the core resumes after its wait instruction, and 0 means the core restarts from its reset vector (default 0xF4000000).
- R9: `aux_reset_hold` follows CTRL bit 0. CTRL bit 31 reads the `aux_sleep` input, and writes to bit 31 are ignored.
- R10: `rd_valid` is 1 in exactly the cycle after each read. `rd_data` holds the value of the addressed register as it stood in the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| aux_sleep | input | 1 | Auxiliary core sleep status |
| aux_reset_hold | output | 1 | Hold auxiliary core in reset |
| aux_nmi | output | 1 | Single-cycle NMI pulse |
| aux_nmi_resume | output | 1 | NMI start behaviour: 1 resume, 0 restart |
| irq_main | output | 1 | Message interrupt toward main core |
| irq_aux | output | 1 | Message interrupt toward aux core |

## Verification
The bench sweeps every combination of current lock value (0 to 3) and access-register tag (0 to 3), and predicts both the read result and the new lock value. This catches three kinds of fault:
- a lock that commits over a holder;
- a lock that commits a zero tag and reports success;
- an access register that loses its stored value after a failed attempt.

For the pending flags, the bench writes a set bit and also reads the message. A flag that was clearing on any write, or on a read, shows up immediately.

It walks all sixteen low-nibble CTRL values and checks the following:
- the NMI lasts exactly one cycle;
- the NMI bit reads back as zero;
- the aux interrupt is gated by the enable bit;
- the sleep bit cannot be written.

A stretched pulse, a sticky NMI bit, or an ungated interrupt would each fail these checks.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int REG_AW  = 3;
    localparam int NUM_ACC = 2;

    localparam int CTRL_HOLD_BIT   = 0;
    localparam int CTRL_NMI_BIT    = 1;
    localparam int CTRL_RESUME_BIT = 2;
    localparam int CTRL_IRQEN_BIT  = 3;

    typedef enum logic [REG_AW-1:0] {
        REG_CTRL      = 3'd0,
        REG_LOCK      = 3'd1,
        REG_ACC_A     = 3'd2,
        REG_ACC_B     = 3'd3,
        REG_MAIN_PEND = 3'd4,
        REG_MAIN_MSG  = 3'd5,
        REG_AUX_PEND  = 3'd6,
        REG_AUX_MSG   = 3'd7
    } reg_sel_e;

    typedef enum logic {LK_FREE, LK_HELD} lock_state_e;
    typedef enum logic {NMI_IDLE, NMI_FIRE} nmi_state_e;
    typedef enum logic {MB_EMPTY, MB_PENDING} mb_state_e;

endpackage

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_wr,
    input  logic              pend_wr,
    input  logic              pend_bit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] msg_o,
    output logic              pend_o
);

    mb_state_e         state_q, state_d;
    logic [DATA_W-1:0] msg_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MB_EMPTY:   if (msg_wr) state_d = MB_PENDING;
            MB_PENDING: if (pend_wr && !pend_bit) state_d = MB_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MB_EMPTY;
            msg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (msg_wr) msg_q <= wdata;
        end
    end

    always_comb begin
        pend_o = (state_q == MB_PENDING);
        msg_o  = msg_q;
    end

endmodule

// File: rtl/mbx_lock.sv
module mbx_lock
    import mbx_pkg::*;
#(
    parameter int LOCK_W = 2,
    parameter int N_ACC  = NUM_ACC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_ACC-1:0]  acc_wr,
    input  logic [N_ACC-1:0]  acc_rd,
    input  logic [LOCK_W-1:0] wval,
    input  logic              release_i,
    output logic [LOCK_W-1:0] lock_o,
    output logic              commit_ok_o
);

    lock_state_e       state_q, state_d;
    logic [LOCK_W-1:0] lock_q, lock_d;
    logic [LOCK_W-1:0] stage_q [N_ACC];
    logic [LOCK_W-1:0] sel_val;
    logic              any_rd;

    for (genvar i = 0; i < N_ACC; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         stage_q[i] <= '0;
            else if (acc_wr[i]) stage_q[i] <= wval;
        end
    end

    always_comb begin
        sel_val = '0;
        any_rd  = 1'b0;
        for (int i = 0; i < N_ACC; i++) begin
            if (acc_rd[i]) begin
                sel_val = sel_val | stage_q[i];
                any_rd  = 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        lock_d  = lock_q;
        unique case (state_q)
            LK_FREE: begin
                if (any_rd && (sel_val != '0)) begin
                    state_d = LK_HELD;
                    lock_d  = sel_val;
                end
            end
            LK_HELD: begin
                if (release_i) begin
                    state_d = LK_FREE;
                    lock_d  = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_FREE;
            lock_q  <= '0;
        end else begin
            state_q <= state_d;
            lock_q  <= lock_d;
        end
    end

    always_comb begin
        lock_o      = lock_q;
        commit_ok_o = (state_q == LK_FREE) && any_rd && (sel_val != '0);
    end

endmodule

// File: rtl/mbx_aux_ctrl.sv
module mbx_aux_ctrl
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [3:0]        ctrl_wdata,
    input  logic              sleep_i,
    output logic              hold_o,
    output logic              nmi_o,
    output logic              resume_o,
    output logic              irq_en_o,
    output logic [DATA_W-1:0] ctrl_rd_o
);

    nmi_state_e state_q, state_d;
    logic       hold_q, resume_q, irq_en_q;
    logic       nmi_req;

    assign nmi_req = ctrl_wr && ctrl_wdata[CTRL_NMI_BIT];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NMI_IDLE: if (nmi_req)  state_d = NMI_FIRE;
            NMI_FIRE: if (!nmi_req) state_d = NMI_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= NMI_IDLE;
            hold_q   <= 1'b1;
            resume_q <= 1'b0;
            irq_en_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ctrl_wr) begin
                hold_q   <= ctrl_wdata[CTRL_HOLD_BIT];
                resume_q <= ctrl_wdata[CTRL_RESUME_BIT];
                irq_en_q <= ctrl_wdata[CTRL_IRQEN_BIT];
            end
        end
    end

    always_comb begin
        hold_o    = hold_q;
        nmi_o     = (state_q == NMI_FIRE);
        resume_o  = resume_q;
        irq_en_o  = irq_en_q;
        ctrl_rd_o = '0;
        ctrl_rd_o[CTRL_HOLD_BIT]   = hold_q;
        ctrl_rd_o[CTRL_RESUME_BIT] = resume_q;
        ctrl_rd_o[CTRL_IRQEN_BIT]  = irq_en_q;
        ctrl_rd_o[DATA_W-1]        = sleep_i;
    end

endmodule

// File: rtl/mbx_intercore.sv
module mbx_intercore
    import mbx_pkg::*;
#(
    parameter int          DATA_W      = 32,
    parameter int          LOCK_W      = 2,
    parameter logic [31:0] BOOT_VECTOR = 32'hF400_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              aux_sleep,
    output logic              aux_reset_hold,
    output logic              aux_nmi,
    output logic              aux_nmi_resume,
    output logic              irq_main,
    output logic              irq_aux
);

    localparam int                NUM_DIR  = 2;
    localparam logic [REG_AW-1:0] ACC_BASE = REG_ACC_A;

    // Restart vector used by the auxiliary core when aux_nmi_resume is 0.
    localparam logic [31:0] RESTART_ADDR = BOOT_VECTOR;

    logic              wr_en, rd_en;
    logic [NUM_ACC-1:0] acc_wr, acc_rd;
    logic [LOCK_W-1:0] lock_val;
    logic              commit_ok;
    logic              irq_en;
    logic [DATA_W-1:0] ctrl_rd;
    logic [DATA_W-1:0] msg  [NUM_DIR];
    logic              pend [NUM_DIR];
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rd_data_q;
    logic              rd_valid_q;

    assign wr_en = bus_en && bus_we;
    assign rd_en = bus_en && !bus_we;

    for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc_dec
        assign acc_wr[i] = wr_en && (bus_addr == REG_AW'(ACC_BASE + i));
        assign acc_rd[i] = rd_en && (bus_addr == REG_AW'(ACC_BASE + i));
    end

    mbx_lock #(
        .LOCK_W (LOCK_W),
        .N_ACC  (NUM_ACC)
    ) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_wr      (acc_wr),
        .acc_rd      (acc_rd),
        .wval        (bus_wdata[LOCK_W-1:0]),
        .release_i   (wr_en && (bus_addr == REG_LOCK)),
        .lock_o      (lock_val),
        .commit_ok_o (commit_ok)
    );

    // Direction 0 carries messages toward the main core, direction 1 toward the aux core.
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_mbox
        localparam logic [REG_AW-1:0] PEND_ADDR = (d == 0) ? REG_MAIN_PEND : REG_AUX_PEND;
        localparam logic [REG_AW-1:0] MSG_ADDR  = (d == 0) ? REG_MAIN_MSG  : REG_AUX_MSG;
        mbx_mailbox #(
            .DATA_W (DATA_W)
        ) u_mbox (
            .clk      (clk),
            .rst_n    (rst_n),
            .msg_wr   (wr_en && (bus_addr == MSG_ADDR)),
            .pend_wr  (wr_en && (bus_addr == PEND_ADDR)),
            .pend_bit (bus_wdata[0]),
            .wdata    (bus_wdata),
            .msg_o    (msg[d]),
            .pend_o   (pend[d])
        );
    end

    mbx_aux_ctrl #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (wr_en && (bus_addr == REG_CTRL)),
        .ctrl_wdata (bus_wdata[3:0]),
        .sleep_i    (aux_sleep),
        .hold_o     (aux_reset_hold),
        .nmi_o      (aux_nmi),
        .resume_o   (aux_nmi_resume),
        .irq_en_o   (irq_en),
        .ctrl_rd_o  (ctrl_rd)
    );

    always_comb begin
        rd_mux = '0;
        unique case (reg_sel_e'(bus_addr))
            REG_CTRL:             rd_mux = ctrl_rd;
            REG_LOCK:             rd_mux[LOCK_W-1:0] = lock_val;
            REG_ACC_A, REG_ACC_B: rd_mux[0] = commit_ok;
            REG_MAIN_PEND:        rd_mux[0] = pend[0];
            REG_MAIN_MSG:         rd_mux = msg[0];
            REG_AUX_PEND:         rd_mux[0] = pend[1];
            REG_AUX_MSG:          rd_mux = msg[1];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= rd_en;
            if (rd_en) rd_data_q <= rd_mux;
        end
    end

    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;
    assign irq_main = pend[0];
    assign irq_aux  = pend[1] && irq_en;

endmodule

// File: rtl/mbx_intercore_chk.sv
module mbx_intercore_chk
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LOCK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [REG_AW-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              rd_valid,
    input logic              aux_nmi,
    input logic              irq_main,
    input logic [LOCK_W-1:0] lock_val
);

    logic wr_main_msg, wr_lock, wr_nmi, rd_any;
    assign wr_main_msg = bus_en && bus_we && (bus_addr == REG_MAIN_MSG);
    assign wr_lock     = bus_en && bus_we && (bus_addr == REG_LOCK);
    assign wr_nmi      = bus_en && bus_we && (bus_addr == REG_CTRL) && bus_wdata[CTRL_NMI_BIT];
    assign rd_any      = bus_en && !bus_we;

    assert_msg_raises_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_main_msg |=> irq_main);

    assert_pend_no_self_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_main && !wr_main_msg) |=> !irq_main);

    assert_held_lock_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((lock_val != '0) && !wr_lock) |=> $stable(lock_val));

    assert_lock_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lock |=> (lock_val == '0));

    assert_nmi_from_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        aux_nmi |-> $past(wr_nmi));

    assert_rd_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_any |=> rd_valid);

endmodule

bind mbx_intercore mbx_intercore_chk #(
    .DATA_W (DATA_W),
    .LOCK_W (LOCK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rd_valid  (rd_valid),
    .aux_nmi   (aux_nmi),
    .irq_main  (irq_main),
    .lock_val  (lock_val)
);

// File: tb/mbx_intercore_tb.sv
module mbx_intercore_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        aux_sleep = 1'b0;
    logic        aux_reset_hold, aux_nmi, aux_nmi_resume, irq_main, irq_aux;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mbx_intercore u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_en         (bus_en),
        .bus_we         (bus_we),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .rd_data        (rd_data),
        .rd_valid       (rd_valid),
        .aux_sleep      (aux_sleep),
        .aux_reset_hold (aux_reset_hold),
        .aux_nmi        (aux_nmi),
        .aux_nmi_resume (aux_nmi_resume),
        .irq_main       (irq_main),
        .irq_aux        (irq_aux)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = rd_data;
        check("R10 rd_valid", 32'(rd_valid), 32'd1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        logic [31:0] pats [4];
        pats[0] = 32'hDEAD_BEEF; pats[1] = 32'h0000_0001;
        pats[2] = 32'hFFFF_FFFF; pats[3] = 32'h8000_0000;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 hold", 32'(aux_reset_hold), 32'd1);
        check("R1 irq_main", 32'(irq_main), 32'd0);
        check("R1 irq_aux", 32'(irq_aux), 32'd0);
        check("R1 nmi", 32'(aux_nmi), 32'd0);
        check("R1 rd_valid", 32'(rd_valid), 32'd0);
        bus_read(3'd0, r); check("R1 ctrl", r, 32'h1);
        bus_read(3'd1, r); check("R1 lock", r, 32'h0);
        bus_read(3'd4, r); check("R1 main pend", r, 32'h0);
        bus_read(3'd6, r); check("R1 aux pend", r, 32'h0);
        @(negedge clk);
        check("R10 rd_valid drops", 32'(rd_valid), 32'd0);

        // R9 sleep bit read-only, hold follows bit 0
        aux_sleep = 1'b1;
        bus_read(3'd0, r); check("R9 sleep visible", r, 32'h8000_0001);
        bus_write(3'd0, 32'h8000_0000);
        check("R9 hold cleared", 32'(aux_reset_hold), 32'd0);
        aux_sleep = 1'b0;
        bus_read(3'd0, r); check("R9 bit31 not writable", r, 32'h0);

        // R8 / R9 sweep of control nibble
        for (int v = 0; v < 16; v++) begin
            bus_write(3'd0, 32'(v));
            check("R9 hold", 32'(aux_reset_hold), 32'(v & 1));
            check("R8 nmi pulse", 32'(aux_nmi), 32'((v >> 1) & 1));
            check("R8 resume", 32'(aux_nmi_resume), 32'((v >> 2) & 1));
            bus_read(3'd0, r);
            check("R8 nmi single cycle", 32'(aux_nmi), 32'd0);
            check("R8 ctrl readback", r, 32'(v & 4'hD));
        end

        // R2 / R4 mailbox toward main
        for (int p = 0; p < 4; p++) begin
            bus_write(3'd5, pats[p]);
            check("R2 irq_main", 32'(irq_main), 32'd1);
            bus_read(3'd4, r); check("R2 pend", r, 32'd1);
            bus_read(3'd5, r); check("R2 msg", r, pats[p]);
            check("R4 read keeps pend", 32'(irq_main), 32'd1);
            bus_write(3'd4, 32'h1);
            check("R4 write 1 no clear", 32'(irq_main), 32'd1);
            bus_write(3'd4, 32'hFFFF_FFFE);
            check("R4 write 0 clears", 32'(irq_main), 32'd0);
            bus_write(3'd4, 32'h1);
            check("R4 write 1 no set", 32'(irq_main), 32'd0);
        end

        // R3 / R4 mailbox toward aux with enable sweep
        for (int en = 0; en < 2; en++) begin
            bus_write(3'd0, 32'(en << 3));
            for (int p = 0; p < 4; p++) begin
                bus_write(3'd7, pats[p]);
                check("R3 irq_aux gated", 32'(irq_aux), 32'(en));
                bus_read(3'd6, r); check("R3 pend", r, 32'd1);
                bus_read(3'd7, r); check("R3 msg", r, pats[p]);
                check("R3 main untouched", 32'(irq_main), 32'd0);
                bus_write(3'd6, 32'h0);
                bus_read(3'd6, r); check("R4 aux clear", r, 32'd0);
                check("R4 irq_aux low", 32'(irq_aux), 32'd0);
            end
        end

        // R5 / R6 / R7 lock sweep: every held value x every tag
        for (int held = 0; held < 4; held++) begin
            for (int v = 0; v < 4; v++) begin
                bus_write(3'd1, 32'h3);
                bus_read(3'd1, r); check("R7 released", r, 32'd0);
                if (held != 0) begin
                    bus_write(3'd2, 32'(held));
                    bus_read(3'd2, r); check("R5 take", r, 32'd1);
                end
                bus_write(3'd3, 32'hFFFF_FFFC | 32'(v));
                bus_read(3'd3, r);
                if (held == 0 && v != 0) begin
                    check("R5 commit ok", r, 32'd1);
                    bus_read(3'd1, r); check("R5 lock value", r, 32'(v));
                end else begin
                    check("R6 commit refused", r, 32'd0);
                    bus_read(3'd1, r); check("R6 lock unchanged", r, 32'(held));
                end
            end
        end

        // R6 retention: failed attempt keeps the tag, later succeeds
        bus_write(3'd1, 32'h0);
        bus_write(3'd2, 32'h1);
        bus_write(3'd3, 32'h2);
        bus_read(3'd2, r); check("R5 A wins", r, 32'd1);
        bus_read(3'd3, r); check("R6 B refused", r, 32'd0);
        bus_write(3'd1, 32'hFFFF_FFFF);
        bus_read(3'd1, r); check("R7 any write releases", r, 32'd0);
        bus_read(3'd3, r); check("R6 B retained and wins", r, 32'd1);
        bus_read(3'd1, r); check("R6 lock holds B tag", r, 32'd2);

        finish_run();
    end

endmodule